// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This receiver takes two-channel serial audio made of a bit clock, a channel-select clock and one data line. It turns each frame into a pair of parallel 24-bit samples. A static input picks one of two framings. In the first, a word starts one bit clock after each channel-select change. In the second, a 16-bit word ends on the last bit clock before the change. Words are always sent most significant bit first and are left-aligned in the 24-bit outputs, with zeros in any bits that were not received.

The block counts bit clocks in every half period. When a half period holds exactly 16 clocks, the next word in the delayed framing is cut to 16 bits, so packed 32-clock frames need no setup. All logic runs on the bit clock, which is the `clk` port. A one-cycle strobe marks each new left/right pair. The first incomplete frame after reset is discarded.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high at a rising edge, `left_out` and `right_out` go to zero and `sample_valid` goes low.
- R2: With `fmt_i2s` high, the first data bit of a half period is taken at the second rising edge of `clk` after `lrck` changes, and it lands in bit 23. Later bits fill lower positions. The word closes after 24 bits or when the half period ends. The bit taken at the first rising edge of the next half period still belongs to the closing word.
- R3: With `fmt_i2s` high, output bits that received no data in the word are zero.
- R4: With `fmt_i2s` high, if the previous half period held exactly 16 rising edges, the current word takes only 16 bits. Bits 7:0 are then zero, however many clocks the half period has.
- R5: With `fmt_i2s` low, the word is the last 16 bits sampled before `lrck` changes, that is, at rising edges where `lrck` still has its old level. These bits go to output bits 23:8, and bits 7:0 are zero.
- R6: A word received while `lrck` is low is the left sample, and a word received while it is high is the right sample. A frame is a left word followed by a right word.
- R7: `sample_valid` is high for exactly one cycle. It rises in the cycle after the rising edge that first sees `lrck` low after a right half period, and only if the left half before it was captured. `left_out` and `right_out` change only together with the strobe.
- R8: After reset, the half period in which reset was released produces no word. A right word with no captured left word before it produces no strobe.
- R9: The two halves of a frame may have different lengths, each from 16 to 127 rising edges, and every frame is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i2s | input | 1 | Framing select: 1 for one-clock-delayed framing, 0 for right-justified 16-bit framing |
| lrck | input | 1 | Channel select clock: low for left, high for right |
| sdata | input | 1 | Serial data, most significant bit first |
| left_out | output | 24 | Left sample of the last complete frame, left-aligned |
| right_out | output | 24 | Right sample of the last complete frame, left-aligned |
| sample_valid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
The assertions take for granted that every half period of `lrck` lasts at least two bit clocks, so one strobe can never follow another directly. They also take for granted that `fmt_i2s` only changes while `rst` is high. The stimulus keeps every half period between 16 and 64 clocks, including many of exactly 16, and it switches framing only inside a reset. The expected words are built from the random bit stream using the requirement rules, so any data beyond the word limit must be ignored by the design.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sarx_half_timer.sv
module sarx_half_timer #(
  parameter int CNT_W  = 7,
  parameter int PACK_N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lrck,
  output logic flip,
  output logic synced,
  output logic short_word,
  output logic prev_lr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] PACK_C  = CNT_W'(PACK_N);

  logic [CNT_W-1:0] cnt;

  assign flip = lrck ^ prev_lr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lr    <= 1'b0;
      cnt        <= '0;
      synced     <= 1'b0;
      short_word <= 1'b0;
    end else begin
      prev_lr <= lrck;
      if (flip) begin
        cnt        <= CNT_W'(1);
        synced     <= 1'b1;
        short_word <= (cnt == PACK_C);
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sarx_i2s_gather.sv
module sarx_i2s_gather #(
  parameter int WORD_W = 24,
  parameter int PACK_N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flip,
  input  logic              short_word,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_o
);
  localparam int TW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] acc;
  logic [TW-1:0]     taken;
  logic [TW-1:0]     lim;

  assign lim = short_word ? TW'(PACK_N) : TW'(WORD_W);

  always_comb begin
    word_o = acc;
    if (taken < lim) begin
      for (int i = 0; i < WORD_W; i++) begin
        if (taken == TW'(WORD_W - 1 - i)) word_o[i] = sdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      taken <= '0;
    end else if (flip) begin
      acc   <= '0;
      taken <= '0;
    end else if (taken < lim) begin
      acc   <= word_o;
      taken <= taken + 1'b1;
    end
  end
endmodule

// File: rtl/sarx_rj_window.sv
module sarx_rj_window #(
  parameter int RJ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sdata,
  output logic [RJ_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= {word_o[RJ_W-2:0], sdata};
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16,
  parameter int PACK_N = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_i2s,
  input  logic              lrck,
  input  logic              sdata,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              sample_valid
);
  import sarx_pkg::*;

  logic              flip, synced, short_word, prev_lr;
  logic [WORD_W-1:0] i2s_word, rj_full, word, left_hold;
  logic [RJ_W-1:0]   rj_word;
  logic              left_ok;
  chan_e             ended_ch;

  sarx_half_timer #(.CNT_W(CNT_W), .PACK_N(PACK_N)) u_timer (
    .clk(clk), .rst(rst), .lrck(lrck), .flip(flip), .synced(synced),
    .short_word(short_word), .prev_lr(prev_lr)
  );

  sarx_i2s_gather #(.WORD_W(WORD_W), .PACK_N(PACK_N)) u_i2s (
    .clk(clk), .rst(rst), .flip(flip), .short_word(short_word),
    .sdata(sdata), .word_o(i2s_word)
  );

  sarx_rj_window #(.RJ_W(RJ_W)) u_rj (
    .clk(clk), .rst(rst), .sdata(sdata), .word_o(rj_word)
  );

  generate
    if (RJ_W < WORD_W) begin : g_pad
      assign rj_full = {rj_word, {(WORD_W-RJ_W){1'b0}}};
    end else begin : g_nopad
      assign rj_full = rj_word[RJ_W-1 -: WORD_W];
    end
  endgenerate

  assign word     = fmt_i2s ? i2s_word : rj_full;
  assign ended_ch = chan_e'(prev_lr);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold    <= '0;
      left_ok      <= 1'b0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (flip && synced) begin
        if (ended_ch == CH_LEFT) begin
          left_hold <= word;
          left_ok   <= 1'b1;
        end else begin
          left_ok <= 1'b0;
          if (left_ok) begin
            left_out     <= left_hold;
            right_out    <= word;
            sample_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              fmt_i2s,
  input logic              lrck,
  input logic [WORD_W-1:0] left_out,
  input logic [WORD_W-1:0] right_out,
  input logic              sample_valid
);
  // R1: the first cycle out of reset shows cleared outputs
  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sample_valid && left_out == '0 && right_out == '0));

  // R7: the strobe lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R7: the outputs hold still without the strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

  // R6: the strobe follows a high-to-low change of the channel clock
  a_r6_after_right: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (!$past(lrck) && $past(lrck, 2)));

  // R5: right-justified words leave the low byte empty
  a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
    !fmt_i2s |-> (left_out[7:0] == 8'h00 && right_out[7:0] == 8'h00));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .lrck(lrck),
  .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt = 1'b1;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_out, right_out;
  logic        sample_valid;

  always #4 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .fmt_i2s(fmt), .lrck(lrck), .sdata(sdata),
    .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid)
  );

  int nvec = 0;
  int nbad = 0;

  // model state
  logic        pev = 1'b0;
  logic [23:0] pel = '0, per = '0;
  logic        last_lr, synced_m, lok;
  logic [23:0] hold, col;
  logic [15:0] hist;
  int          ncol, lim, prev_n;

  task automatic check_prev();
    string tag;
    tag = fmt ? "R2 R3 R4" : "R5";
    nvec++;
    if (sample_valid !== pev) begin
      nbad++;
      $display("FAIL R7 R8 valid: got %b expected %b", sample_valid, pev);
    end
    if (pev) begin
      nvec++;
      if (left_out !== pel) begin
        nbad++;
        $display("FAIL R6 %s R9 left: got %h expected %h", tag, left_out, pel);
      end
      nvec++;
      if (right_out !== per) begin
        nbad++;
        $display("FAIL R6 %s R9 right: got %h expected %h", tag, right_out, per);
      end
    end
  endtask

  task automatic tick(input logic lr, input logic b, input logic ev,
                      input logic [23:0] el, input logic [23:0] er);
    @(negedge clk);
    check_prev();
    rst   = 1'b0;
    lrck  = lr;
    sdata = b;
    pev   = ev;
    pel   = el;
    per   = er;
  endtask

  task automatic do_reset(input logic f);
    @(negedge clk);
    rst = 1'b1; fmt = f; lrck = 1'b0; sdata = 1'b0; pev = 1'b0;
    @(negedge clk);
    nvec++;
    if (sample_valid !== 1'b0 || left_out !== '0 || right_out !== '0) begin
      nbad++;
      $display("FAIL R1 reset: got v=%b l=%h r=%h expected v=0 l=0 r=0",
               sample_valid, left_out, right_out);
    end
    last_lr = 1'b0; synced_m = 1'b0; lok = 1'b0; hold = '0; col = '0;
    hist = '0; ncol = 0; lim = 24; prev_n = 0;
  endtask

  task automatic half(input logic lr, input int n);
    for (int k = 1; k <= n; k++) begin
      logic        b, ev;
      logic [23:0] w, el, er;
      b = 1'($urandom); ev = 1'b0; el = '0; er = '0; w = '0;
      if (k == 1 && lr != last_lr) begin
        if (fmt) begin
          w = col;
          if (ncol < lim) w[23-ncol] = b;   // R2: edge bit closes the word
        end else begin
          w = {hist, 8'h00};                 // R5
        end
        if (synced_m) begin                  // R8
          if (!last_lr) begin
            hold = w; lok = 1'b1;
          end else if (lok) begin
            ev = 1'b1; el = hold; er = w; lok = 1'b0;
          end
        end
        synced_m = 1'b1;
        lim  = (prev_n == 16) ? 16 : 24;     // R4
        col  = '0;
        ncol = 0;
      end else if (ncol < lim) begin
        col[23-ncol] = b;
        ncol++;
      end
      hist = {hist[14:0], b};
      tick(lr, b, ev, el, er);
    end
    last_lr = lr;
    prev_n  = n;
  endtask

  task automatic frame(input int nl, input int nr);
    half(1'b0, nl);
    half(1'b1, nr);
  endtask

  task automatic run_format(input logic f);
    do_reset(f);
    half(1'b0, 5);     // R8: partial half at reset release
    half(1'b1, 24);    // R8: right half with no captured left
    frame(20, 20);
    frame(32, 32);
    frame(24, 24);     // R2: 48-clock packed frame
    frame(16, 16);     // R4: 32-clock packed frame
    frame(16, 16);
    frame(16, 32);     // R4: limit from the previous half
    frame(40, 17);     // R9: unequal halves
    frame(64, 16);
    frame(17, 63);     // R3: short halves pad with zero
    for (int i = 0; i < 150; i++) begin
      int a, c;
      a = ($urandom % 4 == 0) ? 16 : 16 + int'($urandom % 49);
      c = ($urandom % 4 == 0) ? 16 : 16 + int'($urandom % 49);
      frame(a, c);
    end
    half(1'b0, 20);
    tick(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    run_format(1'b1);
    run_format(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule